// File: doc/BRIEF.md
# Multi-Master Semaphore Gate Bank

A bank of hardware lock gates that several bus masters share to protect common resources. Every gate is an eight-bit register that holds zero while free and the owner's tag while taken. A master's tag is its index plus one, so a tag is never zero. The master's identity comes from the bus port it uses, not from the data it writes. To claim a gate, a master writes its own tag and then reads the gate back. The claim succeeded if the value read equals the tag that was written. To free a gate, the owner writes zero.

Two guarded sequencers allow recovery without the owner's help. One forces a single gate, or every gate, back to free. The other clears the unlock-notification flags. Each sequencer needs two back-to-back writes from the same master, and each write must carry a fixed byte pattern.

Each gate keeps one notification bit per master. The bit is set when that master's claim fails. While the bit is set and the gate is free, that master's interrupt line is high.

Top module: `hw_sema_bank`

## Requirements
- R1: After reset every gate reads 0. A gate write is acted on only when its data bits [7:0] equal the writing master's index plus 1, or equal 0. Any other value leaves the gate unchanged.
- R2: A write of a master's own tag takes a gate only when the gate holds 0. A gate held by another master keeps its owner's tag.
- R3: A read issued in one cycle returns its data in the next cycle. For gate addresses 0 to 15, bits [7:0] hold the gate value and bits [15:8] are zero. A port that issued no read in the previous cycle outputs 0.
- R4: A gate goes back to 0 only when its owner writes 0, or through a forced reset. A write of 0 by any other master is ignored.
- R5: When several masters write their tags to the same free gate in one cycle, the lowest-numbered master takes it.
- R6: The gate-reset register is at address 16 and uses two writes. The first write has pattern 0xE2 in bits [7:0]. The second write comes from the same master with pattern 0x1D in bits [7:0] and a gate number in bits [15:8]. A gate number below 16 frees that gate only. A gate number of 64 or more frees every gate. Numbers 16 to 63 free nothing.
- R7: The sequence returns to idle without any effect in two cases: the second write carries the wrong pattern, or it comes from a different master than the first write.
- R8: Reading address 16 or 17 returns the state of that register's sequencer in bits [5:4]. The value is 01 after an accepted first write and 00 when idle. All other bits are 0.
- R9: A tag write that fails sets that master's notification bit for the gate. A tag write that succeeds clears it. irq[m] is high while any gate is 0 and has master m's bit set.
- R10: The notification-reset register is at address 17 and follows the same two-write rules as R6 and R7, with patterns 0x47 and then 0xB8. The selected gate, or all gates for 64 or more, has its notification bits cleared for every master.
- R11: When several masters write the same reset register in one cycle, only the lowest-numbered master's write is used. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | NM | Per-master access request |
| bus_write | input | NM | Per-master write (1) or read (0) |
| bus_addr | input | NM*AW | Per-master address: 0..NG-1 gates, NG gate reset, NG+1 notification reset |
| bus_wdata | input | NM*16 | Per-master write data |
| bus_rdata | output | NM*16 | Per-master read data, one cycle after the read |
| irq | output | NM | Per-master unlock notification |

## Verification
Some situations need more than one master to act in the same cycle or in the cycles right around each other. These are a reset sequence broken by a second master, a release and a claim in one cycle, and two reset-register writes that collide. Directed steps set up each of these explicitly. Random traffic is then limited to a few gates and the two reset registers. It favours the real tags and the four patterns, so armed sequencers are often interrupted by other masters. A bench model predicts every read and the interrupt lines in every cycle.

// File: rtl/hw_sema_bank.sv
module hw_sema_bank #(
  parameter int NG      = 16,
  parameter int NM      = 4,
  parameter int ALLCODE = 64,
  parameter int AW      = $clog2(NG + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    bus_valid,
  input  logic [NM-1:0]    bus_write,
  input  logic [NM*AW-1:0] bus_addr,
  input  logic [NM*16-1:0] bus_wdata,
  output logic [NM*16-1:0] bus_rdata,
  output logic [NM-1:0]    irq
);
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;
  localparam logic [7:0] PAT_A [2] = '{8'hE2, 8'h47};
  localparam logic [7:0] PAT_B [2] = '{8'h1D, 8'hB8};

  logic [7:0]      gate_q [NG];
  logic [7:0]      gate_d [NG];
  logic [NM-1:0]   note_q [NG];
  logic [NM-1:0]   note_d [NG];
  logic [1:0]      seq_arm, seq_fire;
  logic [1:0][7:0] seq_sel;

  always_comb begin
    logic taken;
    for (int g = 0; g < NG; g++) begin
      gate_d[g] = gate_q[g];
      note_d[g] = note_q[g];
      taken = 1'b0;
      for (int m = 0; m < NM; m++) begin
        if (bus_valid[m] && bus_write[m] && bus_addr[m*AW +: AW] == AW'(g)) begin
          if (bus_wdata[m*16 +: 8] == 8'(m + 1)) begin
            if (gate_q[g] == 8'h00 && !taken) begin
              gate_d[g]    = 8'(m + 1);
              taken        = 1'b1;
              note_d[g][m] = 1'b0;
            end else if (gate_q[g] != 8'(m + 1)) begin
              note_d[g][m] = 1'b1;
            end
          end else if (bus_wdata[m*16 +: 8] == 8'h00 && gate_q[g] == 8'(m + 1)) begin
            gate_d[g] = 8'h00;
          end
        end
      end
      if (seq_fire[0] && (int'(seq_sel[0]) >= ALLCODE || int'(seq_sel[0]) == g))
        gate_d[g] = 8'h00;
      if (seq_fire[1] && (int'(seq_sel[1]) >= ALLCODE || int'(seq_sel[1]) == g))
        note_d[g] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        gate_q[g] <= '0;
        note_q[g] <= '0;
      end
    end else begin
      for (int g = 0; g < NG; g++) begin
        gate_q[g] <= gate_d[g];
        note_q[g] <= note_d[g];
      end
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_seq
    logic          wv, arm_q;
    logic [MW-1:0] wm, own_q;
    logic [15:0]   wd;

    always_comb begin
      wv = 1'b0;
      wm = '0;
      wd = '0;
      for (int m = NM - 1; m >= 0; m--) begin
        if (bus_valid[m] && bus_write[m] && bus_addr[m*AW +: AW] == AW'(NG + k)) begin
          wv = 1'b1;
          wm = MW'(m);
          wd = bus_wdata[m*16 +: 16];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        arm_q <= 1'b0;
        own_q <= '0;
      end else if (wv) begin
        arm_q <= !arm_q && wd[7:0] == PAT_A[k];
        if (!arm_q) own_q <= wm;
      end
    end

    assign seq_arm[k]  = arm_q;
    assign seq_fire[k] = wv && arm_q && wm == own_q && wd[7:0] == PAT_B[k];
    assign seq_sel[k]  = wd[15:8];
  end

  for (genvar m = 0; m < NM; m++) begin : g_rd
    logic [AW-1:0] a;
    logic [15:0]   rd_q;
    assign a = bus_addr[m*AW +: AW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else if (bus_valid[m] && !bus_write[m]) begin
        if (a < AW'(NG))          rd_q <= {8'h00, gate_q[a[GW-1:0]]};
        else if (a == AW'(NG))     rd_q <= {10'h000, 1'b0, seq_arm[0], 4'h0};
        else if (a == AW'(NG + 1)) rd_q <= {10'h000, 1'b0, seq_arm[1], 4'h0};
        else                       rd_q <= '0;
      end else rd_q <= '0;
    end

    assign bus_rdata[m*16 +: 16] = rd_q;
  end

  always_comb begin
    irq = '0;
    for (int g = 0; g < NG; g++)
      for (int m = 0; m < NM; m++)
        if (note_q[g][m] && gate_q[g] == 8'h00) irq[m] = 1'b1;
  end
endmodule

// File: rtl/hw_sema_bank_chk.sv
module hw_sema_bank_chk #(
  parameter int NG = 16,
  parameter int NM = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM-1:0]    bus_valid,
  input logic [NM-1:0]    bus_write,
  input logic [NM*16-1:0] bus_rdata,
  input logic [7:0]       gate_q [NG],
  input logic [1:0]       seq_arm
);
  for (genvar g = 0; g < NG; g++) begin : g_gate
    AST_GATE_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      gate_q[g] <= 8'(NM)); // R1
    AST_LOCK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q[g] != 8'h00 && !(|(bus_valid & bus_write))) |=> gate_q[g] == $past(gate_q[g])); // R2
    AST_OWNER_LEAVES_VIA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      gate_q[g] != 8'h00 |=> (gate_q[g] == $past(gate_q[g]) || gate_q[g] == 8'h00)); // R4
  end

  for (genvar m = 0; m < NM; m++) begin : g_port
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid[m] && !bus_write[m]) |=> bus_rdata[m*16 +: 16] == 16'h0000); // R3
  end

  AST_GATE_SEQ_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_arm[0]) |-> $past(|(bus_valid & bus_write))); // R7
  AST_NOTE_SEQ_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_arm[1]) |-> $past(|(bus_valid & bus_write))); // R10
endmodule

bind hw_sema_bank hw_sema_bank_chk #(.NG(NG), .NM(NM)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_rdata(bus_rdata), .gate_q(gate_q), .seq_arm(seq_arm));

// File: tb/tb_hw_sema_bank.sv
module tb_hw_sema_bank;
  localparam int NG = 16, NM = 4, ALL = 64, AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [NM-1:0]    bus_valid, bus_write, irq;
  logic [NM*AW-1:0] bus_addr;
  logic [NM*16-1:0] bus_wdata, bus_rdata;

  hw_sema_bank dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [7:0]    mg [NG];
  logic [NM-1:0] mn [NG];
  logic          marm [2];
  int            mown [2];
  logic          sv [NM], sw [NM];
  logic [AW-1:0] sa [NM];
  logic [15:0]   sd [NM];
  logic [15:0]   last_rd [NM];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rexp(logic [AW-1:0] a);
    if (a < NG) return {8'h00, mg[a]};
    if (a == NG) return marm[0] ? 16'h0010 : 16'h0000;
    if (a == NG + 1) return marm[1] ? 16'h0010 : 16'h0000;
    return 16'h0000;
  endfunction

  function automatic logic [NM-1:0] model_irq();
    logic [NM-1:0] r = '0;
    for (int g = 0; g < NG; g++)
      if (mg[g] == 8'h00) r |= mn[g];
    return r;
  endfunction

  task automatic model_apply();
    logic [7:0]    ng [NG];
    logic [NM-1:0] nn [NG];
    bit            fire [2];
    int            sel [2];
    logic [7:0]    pa [2] = '{8'hE2, 8'h47};
    logic [7:0]    pb [2] = '{8'h1D, 8'hB8};
    for (int g = 0; g < NG; g++) begin
      bit taken = 0;
      ng[g] = mg[g];
      nn[g] = mn[g];
      for (int m = 0; m < NM; m++) begin
        if (sv[m] && sw[m] && sa[m] == g) begin
          if (sd[m][7:0] == 8'(m + 1)) begin
            if (mg[g] == 0 && !taken) begin
              ng[g] = 8'(m + 1); taken = 1; nn[g][m] = 1'b0;
            end else if (mg[g] != 8'(m + 1)) nn[g][m] = 1'b1;
          end else if (sd[m][7:0] == 0 && mg[g] == 8'(m + 1)) ng[g] = 0;
        end
      end
    end
    for (int k = 0; k < 2; k++) begin
      int win = -1;
      fire[k] = 0;
      sel[k] = 0;
      for (int m = NM - 1; m >= 0; m--)
        if (sv[m] && sw[m] && sa[m] == NG + k) win = m;
      if (win >= 0) begin
        if (!marm[k]) begin
          marm[k] = (sd[win][7:0] == pa[k]);
          mown[k] = win;
        end else begin
          fire[k] = (win == mown[k]) && (sd[win][7:0] == pb[k]);
          sel[k] = int'(sd[win][15:8]);
          marm[k] = 0;
        end
      end
    end
    for (int g = 0; g < NG; g++) begin
      if (fire[0] && (sel[0] >= ALL || sel[0] == g)) ng[g] = 0;
      if (fire[1] && (sel[1] >= ALL || sel[1] == g)) nn[g] = '0;
      mg[g] = ng[g];
      mn[g] = nn[g];
    end
  endtask

  task automatic put(int m, bit wr, int a, int d);
    sv[m] = 1'b1; sw[m] = wr; sa[m] = AW'(a); sd[m] = 16'(d);
  endtask

  task automatic step();
    logic [15:0] er [NM];
    for (int m = 0; m < NM; m++) begin
      bus_valid[m] = sv[m];
      bus_write[m] = sw[m];
      bus_addr[m*AW +: AW] = sa[m];
      bus_wdata[m*16 +: 16] = sd[m];
      er[m] = (sv[m] && !sw[m]) ? rexp(sa[m]) : 16'h0000;
    end
    model_apply();
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      last_rd[m] = bus_rdata[m*16 +: 16];
      if (sv[m] && !sw[m] && sa[m] >= NG) chk("R8 reset-register read", 32'(last_rd[m]), 32'(er[m]));
      else chk("R3 read data", 32'(last_rd[m]), 32'(er[m]));
      sv[m] = 1'b0; sw[m] = 1'b0; sa[m] = '0; sd[m] = '0;
    end
    chk("R9 irq lines", 32'(irq), 32'(model_irq()));
    bus_valid = '0;
    bus_write = '0;
  endtask

  task automatic rd_chk(int m, int a, int exp, string req);
    put(m, 1'b0, a, 0);
    step();
    chk(req, 32'(last_rd[m]), 32'(exp));
  endtask

  task automatic wr1(int m, int a, int d);
    put(m, 1'b1, a, d);
    step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    bus_valid = '0; bus_write = '0; bus_addr = '0; bus_wdata = '0;
    for (int m = 0; m < NM; m++) begin
      sv[m] = 0; sw[m] = 0; sa[m] = '0; sd[m] = '0; last_rd[m] = '0;
    end
    for (int g = 0; g < NG; g++) begin mg[g] = '0; mn[g] = '0; end
    marm[0] = 0; marm[1] = 0; mown[0] = 0; mown[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_chk(0, 5, 0, "R1 reset value");
    wr1(1, 3, 2);
    rd_chk(0, 3, 2, "R2 claim of free gate");
    wr1(2, 3, 3);
    rd_chk(3, 3, 2, "R2 claim of held gate refused");
    chk("R9 no irq while held", 32'(irq[2]), 0);
    wr1(2, 4, 5);
    rd_chk(2, 4, 0, "R1 foreign tag ignored");
    wr1(0, 3, 0);
    rd_chk(1, 3, 2, "R4 non-owner zero ignored");
    wr1(1, 3, 0);
    rd_chk(1, 3, 0, "R4 owner release");
    chk("R9 irq after release", 32'(irq[2]), 1);
    wr1(2, 3, 3);
    chk("R9 irq cleared by own claim", 32'(irq[2]), 0);

    put(3, 1'b1, 7, 4); put(1, 1'b1, 7, 2); step();
    rd_chk(0, 7, 2, "R5 lower master wins");

    wr1(0, 16, 16'h00E2);
    rd_chk(2, 16, 16'h0010, "R8 armed state");
    wr1(0, 16, 16'h071D);
    rd_chk(2, 7, 0, "R6 single gate forced free");
    rd_chk(2, 3, 3, "R6 other gate untouched");
    chk("R9 irq after forced free", 32'(irq[3]), 1);
    wr1(0, 17, 16'h0047);
    wr1(0, 17, 16'h07B8);
    chk("R10 notification cleared", 32'(irq[3]), 0);

    wr1(1, 16, 16'h00E2);
    wr1(2, 16, 16'h031D);
    rd_chk(0, 3, 3, "R7 other master aborts");
    rd_chk(0, 16, 0, "R8 idle after abort");
    wr1(1, 16, 16'h00E2);
    wr1(1, 16, 16'h0355);
    rd_chk(0, 3, 3, "R7 wrong pattern aborts");

    wr1(1, 0, 2);
    wr1(0, 16, 16'h00E2);
    wr1(0, 16, 16'h401D);
    rd_chk(0, 0, 0, "R6 reset-all gate 0");
    rd_chk(0, 3, 0, "R6 reset-all gate 3");
    wr1(1, 0, 2);
    wr1(0, 16, 16'h00E2);
    wr1(0, 16, 16'h141D);
    rd_chk(0, 0, 2, "R6 out-of-range number frees nothing");

    put(1, 1'b1, 16, 16'h00E2); put(2, 1'b1, 16, 16'h001D); step();
    rd_chk(3, 16, 16'h0010, "R11 lowest writer arms");
    put(1, 1'b1, 16, 16'h001D); put(0, 1'b1, 16, 16'h00E2); step();
    rd_chk(3, 0, 2, "R11 lower colliding writer wins and aborts");

    for (int i = 0; i < 4000; i++) begin
      for (int m = 0; m < NM; m++) begin
        int r = $urandom % 10;
        int a;
        int d;
        if ($urandom % 3 == 0) continue;
        if (r < 6) a = r % 4;
        else if (r < 8) a = NG;
        else if (r == 8) a = NG + 1;
        else a = $urandom % 32;
        if (a < NG) begin
          case ($urandom % 4)
            0: d = 0;
            1, 2: d = m + 1;
            default: d = $urandom % 256;
          endcase
        end else begin
          int p, s;
          case ($urandom % 5)
            0: p = 8'hE2; 1: p = 8'h1D; 2: p = 8'h47; 3: p = 8'hB8;
            default: p = $urandom % 256;
          endcase
          case ($urandom % 4)
            0: s = 64 + ($urandom % 192);
            1: s = 16 + ($urandom % 48);
            default: s = $urandom % 4;
          endcase
          d = (s << 8) | p;
        end
        put(m, 1'($urandom % 2), a, d);
      end
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule